// File: doc/BRIEF.md
# Flow-Controlled Asynchronous Serial Port

This block is a fast asynchronous serial transmitter and receiver for a system running from a 48 MHz clock. Software programs it through a small register bus. The bit period is given in system clocks, so a value of 24 gives 2.0 Mbaud and 5000 gives 9600 baud.

In byte mode, a register write sends one character and a received character waits in a data register until it is read. In block mode, the port reads a counted run of bytes from memory and sends them, or it stores a counted run of incoming bytes to memory. Memory is reached through a request/grant word port that carries one byte per word.

Two options apply to the transmitter:
- A request-to-send / clear-to-send handshake, which holds back every start bit until the far end allows it.
- A programmable number of stop bits, used between characters in block transmit.

The receive-done interrupt can fire on every character or only when a receive block completes. The transmit-done and receive-done interrupts each have their own enable bit.

The memory port follows stream rules. Once `mem_req` is raised, it stays high with `mem_addr`, `mem_we` and `mem_wdata` unchanged until the cycle in which `mem_gnt` is high. That cycle completes the transfer, and read data must be valid on `mem_rdata` in it. A pending receive write takes the port ahead of a transmit fetch, but only when no request is already waiting for its grant.

Top module: `fc_serial_port`

## Requirements

The register addresses are CTRL=0, BAUD=1, DATA=2, STOP=3, TXPTR=4, TXLEN=5, RXPTR=6 and RXLEN=7.

CTRL has these bits:
- Read and write: bit0 handshake enable, bit1 packet mode, bit2 transmit interrupt enable, bit3 receive interrupt enable.
- Bit4 is the transmit-done flag and bit5 is the receive-done flag. Writing 1 to either one clears it.
- Bit6 is transmit-ready and bit7 is receive-ready. Both are read-only.

- R1: After reset, `txd` is 1, `rts` is 0, both interrupts are 0, transmit-ready reads 1, receive-ready reads 0, and BAUD holds `DEF_BAUD`.
- R2: A DATA write while transmit-ready is 1 sends one frame: a low start bit, 8 data bits least significant first, and one high stop bit. Each bit lasts BAUD clocks.
- R3: Transmit-ready is 0 from an accepted DATA write or block start until the frame or block is finished. A DATA write while it is 0 is ignored and sends nothing.
- R4: With handshake enabled, `rts` rises when a frame is pending, and the start bit is withheld until `cts` is seen high after a two-flop synchronizer. `rts` falls when the transmitter returns to idle. With handshake disabled, `rts` stays 0 and `cts` has no effect.
- R5: Writing a nonzero TXLEN while transmit-ready is 1 sends TXLEN bytes, read from memory at TXPTR upward. Each of these frames ends with the number of stop bits given by STOP[3:0], where 0 counts as 1.
- R6: The receiver times half a bit from a falling `rxd` and accepts the start bit only if `rxd` is still low at that point. It then samples 8 data bits at mid-bit, least significant first. A character whose stop bit samples low is discarded.
- R7: Outside block receive, an accepted character is placed in DATA and sets receive-ready. A DATA read clears receive-ready.
- R8: Writing a nonzero RXLEN starts block receive. The next RXLEN characters are written to memory at RXPTR upward, and receive-ready stays 0.
- R9: With packet mode 0, the receive-done flag sets on every accepted character. With packet mode 1, it sets only when the last write of a receive block completes.
- R10: The transmit-done flag sets at the end of a byte-mode frame, or at the end of the last frame of a block. A CTRL write with bit4 set clears it. An interrupt output is its done flag ANDed with its enable.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; has side effects only for DATA |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Register read data, combinational from `reg_addr` |
| rxd | input | 1 | Serial receive line |
| cts | input | 1 | Clear-to-send from the far end |
| txd | output | 1 | Serial transmit line |
| rts | output | 1 | Request-to-send to the far end |
| tx_irq | output | 1 | Transmit-done interrupt |
| rx_irq | output | 1 | Receive-done interrupt |
| mem_req | output | 1 | Memory request; held until granted |
| mem_we | output | 1 | 1 for a receive write, 0 for a transmit fetch |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Grant; the transfer completes in this cycle |
| mem_rdata | input | 8 | Read byte, valid in the grant cycle |

## Verification

The properties assume the following about the inputs:
- BAUD is at least 4 and does not change while a character is in flight.
- The handshake enable bit does not change during a frame.
- Memory grants a pending receive write before the next character is complete, so no received byte is overwritten.

The stimulus keeps within these limits:
- It programs one bit period of 16 clocks before any traffic.
- It toggles handshake only while the line is idle.
- It answers each memory request after exactly one wait cycle, which is far shorter than a character time.

// File: rtl/fc_serial_pkg.sv
package fc_serial_pkg;
  typedef enum logic [1:0] {TX_IDLE, TX_WAIT, TX_RUN} tx_state_t;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_BAUD  = 3'd1;
  localparam logic [2:0] A_DATA  = 3'd2;
  localparam logic [2:0] A_STOP  = 3'd3;
  localparam logic [2:0] A_TXPTR = 3'd4;
  localparam logic [2:0] A_TXLEN = 3'd5;
  localparam logic [2:0] A_RXPTR = 3'd6;
  localparam logic [2:0] A_RXLEN = 3'd7;

  localparam int B_HS   = 0;
  localparam int B_PKT  = 1;
  localparam int B_TXIE = 2;
  localparam int B_RXIE = 3;
  localparam int B_TXF  = 4;
  localparam int B_RXF  = 5;
  localparam int B_TXR  = 6;
  localparam int B_RXR  = 7;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [1:0] ff;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ff <= {2{RST_VAL}};
    else        ff <= {ff[0], d};

  assign q = ff[1];
endmodule

// File: rtl/fc_tx_engine.sv
module fc_tx_engine
  import fc_serial_pkg::*;
#(
  parameter int TW = 16,
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] baud,
  input  logic          start,
  input  logic [7:0]    data,
  input  logic [GW-1:0] nstop,
  input  logic          hs_en,
  input  logic          cts_s,
  output logic          txd,
  output logic          rts,
  output logic          busy,
  output logic          done
);
  localparam int LW = $clog2(9 + (1 << GW));

  tx_state_t     st;
  logic [8:0]    sr;
  logic [TW-1:0] tmr;
  logic [LW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= TX_IDLE;
      sr   <= '1;
      tmr  <= '0;
      left <= '0;
    end else begin
      case (st)
        TX_IDLE: if (start) begin
          sr   <= {data, 1'b0};
          left <= LW'(8) + LW'(nstop);
          tmr  <= baud - 1'b1;
          st   <= hs_en ? TX_WAIT : TX_RUN;
        end
        TX_WAIT: if (cts_s) st <= TX_RUN;
        TX_RUN: begin
          if (tmr == '0) begin
            if (left == '0) st <= TX_IDLE;
            else begin
              left <= left - 1'b1;
              sr   <= {1'b1, sr[8:1]};
              tmr  <= baud - 1'b1;
            end
          end else tmr <= tmr - 1'b1;
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign busy = (st != TX_IDLE);
  assign done = (st == TX_RUN) && (tmr == '0) && (left == '0);
  assign txd  = (st == TX_RUN) ? sr[0] : 1'b1;
  assign rts  = hs_en && busy;
endmodule

// File: rtl/fc_rx_engine.sv
module fc_rx_engine
  import fc_serial_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] baud,
  input  logic          rx_s,
  output logic          valid,
  output logic [7:0]    data
);
  rx_state_t     st;
  logic [TW-1:0] tmr;
  logic [2:0]    n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= RX_IDLE;
      tmr   <= '0;
      n     <= '0;
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      case (st)
        RX_IDLE: if (!rx_s) begin
          tmr <= (baud >> 1) - 1'b1;
          st  <= RX_START;
        end
        RX_START: begin
          if (tmr == '0) begin
            if (!rx_s) begin
              st  <= RX_DATA;
              tmr <= baud - 1'b1;
              n   <= '0;
            end else st <= RX_IDLE;
          end else tmr <= tmr - 1'b1;
        end
        RX_DATA: begin
          if (tmr == '0) begin
            data <= {rx_s, data[7:1]};
            tmr  <= baud - 1'b1;
            if (n == 3'd7) st <= RX_STOP;
            else           n  <= n + 1'b1;
          end else tmr <= tmr - 1'b1;
        end
        RX_STOP: begin
          if (tmr == '0) begin
            valid <= rx_s;
            st    <= RX_IDLE;
          end else tmr <= tmr - 1'b1;
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fc_serial_port.sv
module fc_serial_port
  import fc_serial_pkg::*;
#(
  parameter int AW       = 16,
  parameter int RW       = 16,
  parameter int GW       = 4,
  parameter int DEF_BAUD = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          rxd,
  input  logic          cts,
  output logic          txd,
  output logic          rts,
  output logic          tx_irq,
  output logic          rx_irq,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_gnt,
  input  logic [7:0]    mem_rdata
);
  logic hs_en, pkt_mode, tx_ie, rx_ie, tx_flag, rx_flag;
  logic [RW-1:0] baud, tx_cnt, rx_cnt;
  logic [GW-1:0] stop_n;
  logic [AW-1:0] tx_addr, rx_addr;
  logic blk_tx, blk_rx, rx_ready, rx_pend, mem_wait, own_rx_q;
  logic [7:0] rx_buf, rx_pend_data;

  logic cts_s, rxd_s, eng_busy, eng_done, rx_valid;
  logic [7:0] rx_data;

  fc_sync #(.RST_VAL(1'b0)) u_cts (.clk(clk), .rst_n(rst_n), .d(cts), .q(cts_s));
  fc_sync #(.RST_VAL(1'b1)) u_rxd (.clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

  wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  wire wr_data = reg_wr && (reg_addr == A_DATA);
  wire rd_data = reg_rd && (reg_addr == A_DATA);

  wire tx_ready = !eng_busy && !blk_tx;
  wire tx_fetch = blk_tx && !eng_busy;
  wire own_rx   = mem_wait ? own_rx_q : rx_pend;

  assign mem_req   = rx_pend || tx_fetch;
  assign mem_we    = own_rx;
  assign mem_addr  = own_rx ? rx_addr : tx_addr;
  assign mem_wdata = rx_pend_data;

  wire xfer     = mem_req && mem_gnt;
  wire rx_wr_ok = xfer && own_rx;
  wire tx_rd_ok = xfer && !own_rx;
  wire byte_go  = wr_data && tx_ready;

  wire [GW-1:0] stop_eff  = (stop_n == '0) ? GW'(1) : stop_n;
  wire          eng_start = byte_go || tx_rd_ok;
  wire [7:0]    eng_data  = tx_rd_ok ? mem_rdata : reg_wdata[7:0];
  wire [GW-1:0] eng_nstop = tx_rd_ok ? stop_eff : GW'(1);

  fc_tx_engine #(.TW(RW), .GW(GW)) u_tx (
    .clk(clk), .rst_n(rst_n), .baud(baud), .start(eng_start), .data(eng_data),
    .nstop(eng_nstop), .hs_en(hs_en), .cts_s(cts_s), .txd(txd), .rts(rts),
    .busy(eng_busy), .done(eng_done));

  fc_rx_engine #(.TW(RW)) u_rx (
    .clk(clk), .rst_n(rst_n), .baud(baud), .rx_s(rxd_s), .valid(rx_valid), .data(rx_data));

  wire tx_last    = eng_done && (!blk_tx || tx_cnt == RW'(1));
  wire rx_blk_end = rx_wr_ok && (rx_cnt == RW'(1));
  wire rx_set     = pkt_mode ? rx_blk_end : rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {hs_en, pkt_mode, tx_ie, rx_ie, tx_flag, rx_flag} <= '0;
      baud <= RW'(DEF_BAUD);
      stop_n <= GW'(1);
      {tx_cnt, rx_cnt} <= '0;
      {tx_addr, rx_addr} <= '0;
      {blk_tx, blk_rx, rx_ready, rx_pend, mem_wait, own_rx_q} <= '0;
      rx_buf <= '0;
      rx_pend_data <= '0;
    end else begin
      mem_wait <= mem_req && !mem_gnt;
      own_rx_q <= own_rx;
      if (wr_ctrl) begin
        hs_en    <= reg_wdata[B_HS];
        pkt_mode <= reg_wdata[B_PKT];
        tx_ie    <= reg_wdata[B_TXIE];
        rx_ie    <= reg_wdata[B_RXIE];
      end
      if (reg_wr && reg_addr == A_BAUD) baud <= reg_wdata;
      if (reg_wr && reg_addr == A_STOP) stop_n <= reg_wdata[GW-1:0];
      // transmit side
      if (tx_last)                          tx_flag <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_TXF]) tx_flag <= 1'b0;
      if (reg_wr && reg_addr == A_TXPTR && !blk_tx) tx_addr <= AW'(reg_wdata);
      if (reg_wr && reg_addr == A_TXLEN && tx_ready && reg_wdata != '0) begin
        tx_cnt <= reg_wdata;
        blk_tx <= 1'b1;
      end
      if (eng_done && blk_tx) begin
        tx_cnt  <= tx_cnt - 1'b1;
        tx_addr <= tx_addr + 1'b1;
        if (tx_cnt == RW'(1)) blk_tx <= 1'b0;
      end
      // receive side
      if (rx_set)                           rx_flag <= 1'b1;
      else if (wr_ctrl && reg_wdata[B_RXF]) rx_flag <= 1'b0;
      if (reg_wr && reg_addr == A_RXPTR && !blk_rx) rx_addr <= AW'(reg_wdata);
      if (reg_wr && reg_addr == A_RXLEN && !blk_rx && reg_wdata != '0) begin
        rx_cnt <= reg_wdata;
        blk_rx <= 1'b1;
      end
      if (rx_wr_ok) begin
        rx_pend <= 1'b0;
        rx_addr <= rx_addr + 1'b1;
        rx_cnt  <= rx_cnt - 1'b1;
        if (rx_cnt == RW'(1)) blk_rx <= 1'b0;
      end
      if (rd_data) rx_ready <= 1'b0;
      if (rx_valid) begin
        if (blk_rx) begin
          rx_pend      <= 1'b1;
          rx_pend_data <= rx_data;
        end else begin
          rx_buf   <= rx_data;
          rx_ready <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_HS]   = hs_en;
        reg_rdata[B_PKT]  = pkt_mode;
        reg_rdata[B_TXIE] = tx_ie;
        reg_rdata[B_RXIE] = rx_ie;
        reg_rdata[B_TXF]  = tx_flag;
        reg_rdata[B_RXF]  = rx_flag;
        reg_rdata[B_TXR]  = tx_ready;
        reg_rdata[B_RXR]  = rx_ready;
      end
      A_BAUD:  reg_rdata = baud;
      A_DATA:  reg_rdata = RW'(rx_buf);
      A_STOP:  reg_rdata = RW'(stop_n);
      A_TXPTR: reg_rdata = RW'(tx_addr);
      A_TXLEN: reg_rdata = tx_cnt;
      A_RXPTR: reg_rdata = RW'(rx_addr);
      default: reg_rdata = rx_cnt;
    endcase
  end

  assign tx_irq = tx_flag && tx_ie;
  assign rx_irq = rx_flag && rx_ie;
endmodule

// File: rtl/fc_serial_port_chk.sv
module fc_serial_port_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          txd,
  input logic          rts,
  input logic          hs_en,
  input logic          tx_ready,
  input logic          mem_req,
  input logic          mem_gnt,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          tx_flag,
  input logic          eng_done,
  input logic          rx_ready,
  input logic          rx_valid,
  input logic          blk_rx
);
  // R4
  start_gated_by_rts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en && $fell(txd) |-> rts);

  // R3
  ready_low_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> !tx_ready);

  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  // R8
  rx_write_in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> blk_rx);

  // R10
  tx_flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_flag) |-> $past(eng_done));

  // R7
  rx_ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_valid));
endmodule

bind fc_serial_port fc_serial_port_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .rts(rts), .hs_en(hs_en),
  .tx_ready(tx_ready), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_we(mem_we),
  .mem_addr(mem_addr), .tx_flag(tx_flag), .eng_done(eng_done),
  .rx_ready(rx_ready), .rx_valid(rx_valid), .blk_rx(blk_rx));

// File: tb/fc_serial_port_test.sv
module fc_serial_port_test;
  localparam int BP = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic rxd = 1'b1, cts = 1'b0;
  logic txd, rts, tx_irq, rx_irq, mem_req, mem_we, mem_gnt = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic [7:0] mem [16];

  int nchk = 0, nfail = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];
  int gap_q[$];

  fc_serial_port uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .cts(cts), .txd(txd),
    .rts(rts), .tx_irq(tx_irq), .rx_irq(rx_irq), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata));

  always #5 clk = ~clk;

  // memory model: grant after one wait cycle
  assign mem_rdata = mem[mem_addr[3:0]];
  always @(posedge clk) begin
    if (mem_req && mem_gnt && mem_we) mem[mem_addr[3:0]] <= mem_wdata;
    mem_gnt <= mem_req && !mem_gnt;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // driver side of the scoreboard
  task automatic send_tx(input logic [7:0] b);
    exp_q.push_back(b);
    reg_write(3'd2, {8'h00, b});
  endtask

  task automatic send_rx(input logic [7:0] b, input bit stop_ok);
    @(negedge clk); rxd = 1'b0; repeat (BP) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = b[i]; repeat (BP) @(negedge clk); end
    rxd = stop_ok; repeat (BP) @(negedge clk);
    rxd = 1'b1; repeat (BP) @(negedge clk);
  endtask

  task automatic wait_tx_irq();
    for (int i = 0; i < 5000 && !tx_irq; i++) @(negedge clk);
  endtask

  // monitor side of the scoreboard: decodes txd frames
  initial begin
    logic [7:0] b, e;
    int run;
    bit have_start;
    have_start = 0;
    @(posedge rst_n);
    forever begin
      if (!have_start) begin
        @(negedge clk);
        while (txd !== 1'b0) @(negedge clk);
      end
      have_start = 0;
      repeat (BP/2) @(negedge clk);
      chk(txd === 1'b0, "R2 start bit", txd, 0);
      for (int i = 0; i < 8; i++) begin repeat (BP) @(negedge clk); b[i] = txd; end
      repeat (BP) @(negedge clk);
      chk(txd === 1'b1, "R2 stop bit", txd, 1);
      if (exp_q.size() == 0) chk(0, "R3 unexpected frame", b, 0);
      else begin
        e = exp_q.pop_front();
        chk(b === e, "R2 frame data LSB first", b, e);
      end
      run = 0;
      while (txd === 1'b1 && run < 4*BP) begin @(negedge clk); run++; end
      if (txd === 1'b0) begin gap_q.push_back(run); have_start = 1; end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    mem[4] = 8'h81; mem[5] = 8'h42; mem[6] = 8'hE7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd === 1'b1 && rts === 1'b0, "R1 line idle", {txd, rts}, 2'b10);
    chk(tx_irq === 1'b0 && rx_irq === 1'b0, "R1 irqs low", {tx_irq, rx_irq}, 0);
    reg_read(3'd0, r);
    chk(r[6] == 1'b1 && r[7] == 1'b0, "R1 ready bits", r[7:6], 2'b01);
    reg_read(3'd1, r);
    chk(r == 16'd24, "R1 default baud", r, 24);

    reg_write(3'd1, BP);
    reg_write(3'd0, 16'h000C);

    // R2/R3 byte mode; second write while busy must be ignored
    send_tx(8'hA5);
    reg_read(3'd0, r);
    chk(r[6] == 1'b0, "R3 tx_ready low while sending", r[6], 0);
    reg_write(3'd2, 16'h0011);
    wait_tx_irq();
    chk(tx_irq === 1'b1, "R10 tx irq after byte frame", tx_irq, 1);
    reg_write(3'd0, 16'h001C);
    chk(tx_irq === 1'b0, "R10 W1C clears tx flag", tx_irq, 0);

    // R4 handshake
    reg_write(3'd0, 16'h000D);
    send_tx(8'h3C);
    repeat (50) @(negedge clk);
    chk(rts === 1'b1, "R4 rts raised while pending", rts, 1);
    chk(txd === 1'b1, "R4 start held without cts", txd, 1);
    cts = 1'b1;
    wait_tx_irq();
    @(negedge clk);
    chk(rts === 1'b0, "R4 rts dropped when idle", rts, 0);
    reg_write(3'd0, 16'h001C);
    cts = 1'b0;

    // R6/R7/R9 byte receive, per-character flag
    send_rx(8'h5A, 1'b1);
    chk(rx_irq === 1'b1, "R9 rx flag per byte", rx_irq, 1);
    reg_read(3'd0, r);
    chk(r[7] == 1'b1, "R7 rx_ready set", r[7], 1);
    reg_read(3'd2, r);
    chk(r[7:0] == 8'h5A, "R6 rx data", r[7:0], 8'h5A);
    reg_read(3'd0, r);
    chk(r[7] == 1'b0, "R7 read clears rx_ready", r[7], 0);
    reg_write(3'd0, 16'h002C);
    chk(rx_irq === 1'b0, "R9 rx flag W1C", rx_irq, 0);

    // R6 glitch rejection
    @(negedge clk); rxd = 1'b0; repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (12*BP) @(negedge clk);
    reg_read(3'd0, r);
    chk(r[7] == 1'b0 && r[5] == 1'b0, "R6 short pulse rejected", r[7:5], 0);

    // R6 framing error discards
    send_rx(8'h77, 1'b0);
    reg_read(3'd0, r);
    chk(r[7] == 1'b0, "R6 bad stop discarded", r[7], 0);

    // R5/R10 block transmit with two stop bits
    reg_write(3'd3, 16'd2);
    reg_write(3'd4, 16'd4);
    exp_q.push_back(8'h81); exp_q.push_back(8'h42); exp_q.push_back(8'hE7);
    gap_q.delete();
    reg_write(3'd5, 16'd3);
    repeat (200) @(negedge clk);
    chk(tx_irq === 1'b0, "R10 no flag mid block", tx_irq, 0);
    wait_tx_irq();
    chk(tx_irq === 1'b1, "R10 flag at block end", tx_irq, 1);
    repeat (4*BP + 8) @(negedge clk);
    chk(gap_q.size() == 2, "R5 back-to-back frames", gap_q.size(), 2);
    foreach (gap_q[i])
      chk(gap_q[i] >= 2*BP - BP/2 && gap_q[i] < 2*BP, "R5 stop bits between frames", gap_q[i], 2*BP - 4);
    reg_read(3'd0, r);
    chk(r[6] == 1'b1, "R3 ready after block", r[6], 1);
    reg_write(3'd0, 16'h003C);

    // R8/R9 block receive, packet mode
    reg_write(3'd0, 16'h000E);
    reg_write(3'd6, 16'd8);
    reg_write(3'd7, 16'd2);
    send_rx(8'hC3, 1'b1);
    chk(rx_irq === 1'b0, "R9 no packet flag mid block", rx_irq, 0);
    send_rx(8'h19, 1'b1);
    chk(rx_irq === 1'b1, "R9 packet flag at block end", rx_irq, 1);
    chk(mem[8] == 8'hC3 && mem[9] == 8'h19, "R8 bytes stored", {mem[8], mem[9]}, 16'hC319);
    reg_read(3'd0, r);
    chk(r[7] == 1'b0, "R8 rx_ready untouched", r[7], 0);

    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all expected frames seen", exp_q.size(), 0);

    finished = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule